// File: doc/BRIEF.md
# Quad Wiper Register Target on a Two-Wire Bus

This block is the serial target side of a four-channel digital potentiometer. It watches an oversampled, already synchronized two-wire bus (SCL and SDA sampled on the system clock) and pulls SDA low through an open-drain enable when it acknowledges or sends a zero. It recognizes START, repeated START and STOP. It answers to a 7-bit device identity made of a fixed `1010` prefix and three strap pins.

After the identity, the host sends a register pointer byte. The host can then write one or more data bytes, or use a repeated START with the read identity to read one or more bytes back. Five volatile byte registers sit behind the pointer: four wiper positions at pointers 0 to 3 and a control register at pointer 10h, which holds the shutdown enable.

The register contents and a one-cycle write strobe, with the register pointer it applied to, go straight to the downstream wiper and shutdown logic.

Top module: `dpot_i2c_target`

## Requirements
- R1: After reset all four wiper registers and the control register hold 40h, and SDA is not driven.
- R2: The target acknowledges a byte following START only if its upper seven bits equal `1010` followed by strap pins [2:1:0]. Bit 0 selects the direction: 1 for read, 0 for write. For any other byte it drives nothing until the next START.
- R3: A pointer byte of 00h to 03h or 10h is acknowledged. Any other pointer is not acknowledged, and the following bytes are neither acknowledged nor written until the next START. The write strobe only ever carries a legal pointer.
- R4: Every data byte of a write is acknowledged. It is committed through a one-cycle write strobe raised during the high phase of its ninth SCL clock. No register changes without that strobe.
- R5: Further data bytes in one write go to the next wiper pointer. At pointer 3 the pointer stays at 3, and at pointer 10h it stays at 10h.
- R6: A write to a wiper register stores bits [6:0] and clears bit 7.
- R7: In the control register only bit 6 (shutdown enable) can be written. All other bits always read 0.
- R8: A read returns the register at the current pointer, MSB first, with bits changing after SCL falling edges. A host acknowledge advances the pointer under the rule of R5 and sends the next byte. A host not-acknowledge ends the transfer.
- R9: A STOP returns the target to idle and releases SDA. Bytes clocked after it without a new START are not acknowledged.
- R10: A repeated START at any point restarts identity matching while keeping the current pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized serial clock |
| sda_i | input | 1 | Synchronized serial data as seen on the bus |
| strap_i | input | 3 | Device identity strap pins |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| wiper_o | output | 32 | Four wiper registers, channel n at bits [8n+7:8n] |
| ctl_o | output | 8 | Control register (bit 6 = shutdown enable) |
| wr_stb_o | output | 1 | One-cycle strobe when a data byte is committed |
| wr_addr_o | output | 8 | Register pointer that the strobe applies to |

## Verification
The bench builds the block with its default parameters: four wiper channels, the control register at 10h and the reset value 40h. The straps are tied to 101b. With only four channels, a four-byte sequential access runs into the pointer ceiling at 3. The pointers 04h and 05h lie in the gap between the last wiper and the control register, so the acknowledge decision for illegal pointers is exercised. Mismatching straps and a wrong prefix test identity rejection, and a STOP followed by a byte without START tests the return to idle.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ID,
    ST_ID_ACK,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RACK,
    ST_SKIP
  } xfer_st_e;
endpackage

// File: rtl/dpot_bus_cond.sv
// Edge and bus-condition detection on the oversampled SCL/SDA pair.
module dpot_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/dpot_xfer_fsm.sv
// Byte/bit sequencer: identity match, pointer, write and read phases.
module dpot_xfer_fsm
  import dpot_pkg::*;
#(
  parameter int          NCH       = 4,
  parameter logic [3:0]  ID_PREFIX = 4'b1010,
  parameter logic [7:0]  CTL_ADDR  = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start,
  input  logic              stop,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              wr_stb_o,
  output logic [BYTE_W-1:0] ptr_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam logic [BYTE_W-1:0] LAST_CH = BYTE_W'(NCH - 1);

  xfer_st_e          st, st_d;
  logic [3:0]        cnt, cnt_d;
  logic [BYTE_W-1:0] sr, sr_d;
  logic [BYTE_W-1:0] ptr, ptr_d, ptr_nx;
  logic              rw, rw_d, mack, mack_d, stb, stb_d;
  logic              id_hit, addr_ok, byte_end;

  assign id_hit   = (sr[7:1] == {ID_PREFIX, strap_i});
  assign addr_ok  = (sr <= LAST_CH) || (sr == CTL_ADDR);
  assign ptr_nx   = (ptr < LAST_CH) ? ptr + 1'b1 : ptr;
  assign byte_end = scl_fall && (cnt == 4'd8);

  always_comb begin
    st_d   = st;
    cnt_d  = cnt;
    sr_d   = sr;
    ptr_d  = ptr;
    rw_d   = rw;
    mack_d = mack;
    stb_d  = 1'b0;
    if (stop) begin
      st_d = ST_IDLE;
    end else if (start) begin
      st_d  = ST_ID;
      cnt_d = 4'd0;
    end else begin
      unique case (st)
        ST_ID, ST_ADDR, ST_WDAT: begin
          if (scl_rise) begin
            sr_d  = {sr[BYTE_W-2:0], sda_i};
            cnt_d = cnt + 4'd1;
          end else if (byte_end) begin
            cnt_d = 4'd0;
            if (st == ST_ID) begin
              if (id_hit) begin
                st_d = ST_ID_ACK;
                rw_d = sr[0];
              end else begin
                st_d = ST_SKIP;
              end
            end else if (st == ST_ADDR) begin
              if (addr_ok) begin
                st_d  = ST_ADDR_ACK;
                ptr_d = sr;
              end else begin
                st_d = ST_SKIP;
              end
            end else begin
              st_d = ST_WDAT_ACK;
            end
          end
        end
        ST_ID_ACK: begin
          if (scl_fall) begin
            cnt_d = 4'd0;
            if (rw) begin
              st_d = ST_RDAT;
              sr_d = rd_data_i;
            end else begin
              st_d = ST_ADDR;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            st_d  = ST_WDAT;
            cnt_d = 4'd0;
          end
        end
        ST_WDAT_ACK: begin
          if (scl_rise) stb_d = 1'b1;
          if (scl_fall) begin
            st_d  = ST_WDAT;
            cnt_d = 4'd0;
            ptr_d = ptr_nx;
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (cnt == 4'd7) begin
              st_d  = ST_RACK;
              cnt_d = 4'd0;
            end else begin
              sr_d  = {sr[BYTE_W-2:0], 1'b0};
              cnt_d = cnt + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_i;
            if (!sda_i) ptr_d = ptr_nx;
          end else if (scl_fall) begin
            if (mack) begin
              st_d = ST_RDAT;
              sr_d = rd_data_i;
            end else begin
              st_d = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= 4'd0;
      sr   <= '0;
      ptr  <= '0;
      rw   <= 1'b0;
      mack <= 1'b0;
      stb  <= 1'b0;
    end else begin
      st   <= st_d;
      cnt  <= cnt_d;
      sr   <= sr_d;
      ptr  <= ptr_d;
      rw   <= rw_d;
      mack <= mack_d;
      stb  <= stb_d;
    end
  end

  assign sda_oe_o  = (st == ST_ID_ACK) || (st == ST_ADDR_ACK) || (st == ST_WDAT_ACK)
                  || ((st == ST_RDAT) && !sr[BYTE_W-1]);
  assign wr_stb_o  = stb;
  assign ptr_o     = ptr;
  assign wr_data_o = sr;
endmodule

// File: rtl/dpot_regfile.sv
// Four wiper registers and the control register, with masked writes.
module dpot_regfile
  import dpot_pkg::*;
#(
  parameter int          NCH      = 4,
  parameter logic [7:0]  CTL_ADDR = 8'h10,
  parameter logic [7:0]  RST_VAL  = 8'h40,
  parameter int          SHDN_BIT = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_stb,
  input  logic [BYTE_W-1:0]     wr_addr,
  input  logic [BYTE_W-1:0]     wr_data,
  input  logic [BYTE_W-1:0]     rd_addr,
  output logic [BYTE_W-1:0]     rd_data,
  output logic [NCH*BYTE_W-1:0] wiper_o,
  output logic [BYTE_W-1:0]     ctl_o
);
  localparam logic [BYTE_W-1:0] WIPER_MASK = {1'b0, {(BYTE_W-1){1'b1}}};
  localparam logic [BYTE_W-1:0] CTL_MASK   = BYTE_W'(1) << SHDN_BIT;

  logic [BYTE_W-1:0] wreg [NCH];
  logic [BYTE_W-1:0] ctl;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic wen;
    assign wen = wr_stb && (wr_addr == BYTE_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   wreg[g] <= RST_VAL & WIPER_MASK;
      else if (wen) wreg[g] <= wr_data & WIPER_MASK;
    end
    assign wiper_o[g*BYTE_W +: BYTE_W] = wreg[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              ctl <= RST_VAL & CTL_MASK;
    else if (wr_stb && wr_addr == CTL_ADDR)  ctl <= wr_data & CTL_MASK;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NCH; i++)
      if (rd_addr == BYTE_W'(i)) rd_data = wreg[i];
    if (rd_addr == CTL_ADDR) rd_data = ctl;
  end

  assign ctl_o = ctl;
endmodule

// File: rtl/dpot_i2c_target.sv
module dpot_i2c_target
  import dpot_pkg::*;
#(
  parameter int          NCH       = 4,
  parameter logic [3:0]  ID_PREFIX = 4'b1010,
  parameter logic [7:0]  CTL_ADDR  = 8'h10,
  parameter logic [7:0]  RST_VAL   = 8'h40,
  parameter int          SHDN_BIT  = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [2:0]            strap_i,
  output logic                  sda_oe_o,
  output logic [NCH*BYTE_W-1:0] wiper_o,
  output logic [BYTE_W-1:0]     ctl_o,
  output logic                  wr_stb_o,
  output logic [BYTE_W-1:0]     wr_addr_o
);
  logic [1:0]        rst_q;
  logic              srst_n;
  logic              scl_rise, scl_fall, start, stop;
  logic [BYTE_W-1:0] ptr, wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign srst_n = rst_q[1];

  dpot_bus_cond u_cond (
    .clk(clk), .rst_n(srst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall), .start_o(start), .stop_o(stop)
  );

  dpot_xfer_fsm #(.NCH(NCH), .ID_PREFIX(ID_PREFIX), .CTL_ADDR(CTL_ADDR)) u_fsm (
    .clk(clk), .rst_n(srst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start(start), .stop(stop), .sda_i(sda_i), .strap_i(strap_i),
    .rd_data_i(rd_data), .sda_oe_o(sda_oe_o), .wr_stb_o(wr_stb_o),
    .ptr_o(ptr), .wr_data_o(wr_data)
  );

  dpot_regfile #(.NCH(NCH), .CTL_ADDR(CTL_ADDR), .RST_VAL(RST_VAL), .SHDN_BIT(SHDN_BIT)) u_regs (
    .clk(clk), .rst_n(srst_n), .wr_stb(wr_stb_o), .wr_addr(ptr), .wr_data(wr_data),
    .rd_addr(ptr), .rd_data(rd_data), .wiper_o(wiper_o), .ctl_o(ctl_o)
  );

  assign wr_addr_o = ptr;
endmodule

// File: rtl/dpot_i2c_target_chk.sv
module dpot_i2c_target_chk #(
  parameter int         NCH      = 4,
  parameter logic [7:0] CTL_ADDR = 8'h10,
  parameter int         SHDN_BIT = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             sda_i,
  input logic             sda_oe_o,
  input logic [NCH*8-1:0] wiper_o,
  input logic [7:0]       ctl_o,
  input logic             wr_stb_o,
  input logic [7:0]       wr_addr_o
);
  localparam logic [7:0] CTL_MASK = 8'(1) << SHDN_BIT;
  localparam logic [7:0] LAST_CH  = 8'(NCH - 1);

  logic [NCH-1:0] msb;
  for (genvar g = 0; g < NCH; g++) begin : g_msb
    assign msb[g] = wiper_o[g*8+7];
  end

  // R6
  wiper_msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) msb == '0);

  // R7
  ctl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n) (ctl_o & ~CTL_MASK) == 8'h00);

  // R4
  wr_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> (sda_oe_o && scl_i));

  // R4
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_stb_o) |-> ($stable(wiper_o) && $stable(ctl_o)));

  // R3
  addr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> ((wr_addr_o <= LAST_CH) || (wr_addr_o == CTL_ADDR)));

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !sda_oe_o);
endmodule

bind dpot_i2c_target dpot_i2c_target_chk #(.NCH(NCH), .CTL_ADDR(CTL_ADDR), .SHDN_BIT(SHDN_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_oe_o(sda_oe_o),
  .wiper_o(wiper_o), .ctl_o(ctl_o), .wr_stb_o(wr_stb_o), .wr_addr_o(wr_addr_o)
);

// File: tb/sim_dpot_i2c_target.sv
module sim_dpot_i2c_target;
  localparam int CLK_P = 10;
  localparam int Q     = 4;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] IDW   = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] IDR   = {4'b1010, STRAP, 1'b1};
  // {pointer, written byte, expected readback}
  localparam logic [23:0] VEC [0:5] = '{
    24'h00_12_12, 24'h01_FF_7F, 24'h02_80_00,
    24'h03_55_55, 24'h10_FF_40, 24'h10_00_00
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_bus;
  logic sda_oe;
  logic [31:0] wiper;
  logic [7:0]  ctl, wr_addr;
  logic        wr_stb;
  int nchk = 0, nerr = 0, stb_n = 0;
  logic stb_scl = 1'b0;
  logic [7:0] stb_addr = 8'h00;
  logic done = 1'b0;

  always #(CLK_P/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  dpot_i2c_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .strap_i(STRAP),
    .sda_oe_o(sda_oe), .wiper_o(wiper), .ctl_o(ctl), .wr_stb_o(wr_stb), .wr_addr_o(wr_addr)
  );

  always @(posedge clk) if (wr_stb) begin
    stb_n    <= stb_n + 1;
    stb_scl  <= scl_m;
    stb_addr <= wr_addr;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0;
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q/2);
    ack = ~sda_bus; tick(Q/2); scl_m = 1'b0; tick(1);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q/2); b[i] = sda_bus; tick(Q/2); scl_m = 1'b0;
    end
    sda_m = ~mack; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0; tick(1); sda_m = 1'b1;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d,
                        output logic ka, output logic kb, output logic kc);
    bus_start(); send_byte(IDW, ka); send_byte(a, kb); send_byte(d, kc); bus_stop();
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    logic k;
    bus_start(); send_byte(IDW, k); send_byte(a, k);
    bus_start(); send_byte(IDR, k); recv_byte(1'b0, d); bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL R9 watchdog expired actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic ka, kb, kc;
    logic [7:0] rd;
    int s0;
    tick(3); rst_n = 1'b1; tick(4);
    // R1 reset state
    check("R1 wipers", wiper, 32'h40404040);
    check("R1 ctl", {24'h0, ctl}, 32'h40);
    check("R1 sda", {31'h0, sda_oe}, 32'h0);

    // vector table: single write then random read
    for (int v = 0; v < 6; v++) begin
      s0 = stb_n;
      wr_reg(VEC[v][23:16], VEC[v][15:8], ka, kb, kc);
      check("R2 id ack", {31'h0, ka}, 32'h1);
      check("R3 ptr ack", {31'h0, kb}, 32'h1);
      check("R4 data ack", {31'h0, kc}, 32'h1);
      check("R4 one strobe", stb_n - s0, 32'h1);
      check("R4 ninth clock high", {31'h0, stb_scl}, 32'h1);
      check("R4 strobe ptr", {24'h0, stb_addr}, {24'h0, VEC[v][23:16]});
      rd_reg(VEC[v][23:16], rd);
      // R6 wiper bit7 cleared, R7 only bit 6 of control kept
      check(VEC[v][23:16] == 8'h10 ? "R7 readback" : "R6 readback", {24'h0, rd}, {24'h0, VEC[v][7:0]});
    end
    check("R6 wiper port", wiper, 32'h55007F12);
    check("R7 ctl port", {24'h0, ctl}, 32'h0);

    // R2 strap mismatch and prefix mismatch
    s0 = stb_n;
    wr_reg(8'h00, 8'h33, ka, kb, kc);
    wr_reg(8'h00, 8'h33, ka, kb, kc);
    bus_start(); send_byte({4'b1010, 3'b010, 1'b0}, ka); send_byte(8'h00, kb); send_byte(8'h33, kc); bus_stop();
    check("R2 strap nack", {29'h0, ka, kb, kc}, 32'h0);
    bus_start(); send_byte({4'b0010, STRAP, 1'b0}, ka); bus_stop();
    check("R2 prefix nack", {31'h0, ka}, 32'h0);
    check("R2 no write", wiper[7:0], 8'h33);
    wr_reg(8'h00, 8'h12, ka, kb, kc);

    // R3 pointers just past last channel are refused
    s0 = stb_n;
    wr_reg(8'h04, 8'h66, ka, kb, kc);
    check("R3 ptr 04", {29'h0, ka, kb, kc}, 32'h4);
    wr_reg(8'h05, 8'h66, ka, kb, kc);
    check("R3 ptr 05", {29'h0, ka, kb, kc}, 32'h4);
    check("R3 no strobe", stb_n - s0, 32'h0);
    check("R3 regs kept", wiper, 32'h55007F12);

    // R5 sequential write saturating at 3
    bus_start(); send_byte(IDW, ka); send_byte(8'h02, kb);
    send_byte(8'h11, ka); send_byte(8'h22, kb); send_byte(8'h33, kc); bus_stop();
    check("R5 all acked", {29'h0, ka, kb, kc}, 32'h7);
    check("R5 seq result", wiper, 32'h33117F12);

    // R8 sequential read with host acks, then nack
    bus_start(); send_byte(IDW, ka); send_byte(8'h00, ka);
    bus_start(); send_byte(IDR, ka);
    recv_byte(1'b1, rd); check("R8 byte0", {24'h0, rd}, 32'h12);
    recv_byte(1'b1, rd); check("R8 byte1", {24'h0, rd}, 32'h7F);
    recv_byte(1'b1, rd); check("R8 byte2", {24'h0, rd}, 32'h11);
    recv_byte(1'b1, rd); check("R8 byte3", {24'h0, rd}, 32'h33);
    recv_byte(1'b0, rd); check("R5 read holds at 3", {24'h0, rd}, 32'h33);
    bus_stop();
    check("R8 released", {31'h0, sda_oe}, 32'h0);

    // R9 byte after STOP without START
    scl_m = 1'b0; tick(Q);
    send_byte(IDW, ka);
    check("R9 idle nack", {31'h0, ka}, 32'h0);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);

    // R10 repeated START after pointer restarts identity, pointer kept
    bus_start(); send_byte(IDW, ka); send_byte(8'h01, kb);
    bus_start(); send_byte(IDW, ka); send_byte(8'h00, kb); send_byte(8'h5A, kc); bus_stop();
    check("R10 restart write", wiper, 32'h33117F5A);
    bus_start(); send_byte(IDW, ka); send_byte(8'h03, kb);
    bus_start(); send_byte(IDR, ka); recv_byte(1'b0, rd); bus_stop();
    check("R10 pointer kept", {24'h0, rd}, 32'h33);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule